// File: doc/BRIEF.md
# Two-Stage Ranked Candidate Sorter

The block takes a full event of track candidates every clock: twelve angular wedges with twelve candidate inputs each, 144 in all. Each candidate carries a quality code, a transverse-momentum code, a wedge tag and a sub-sector index. An optional duplicate-suppression pass first removes candidates that are probably copies of a neighbour. A per-wedge stage then keeps the two strongest survivors of each wedge, so that close pairs of real tracks are not lost. A global stage then picks the four strongest candidates over all wedges.

The block is fully pipelined. A new event can be presented on every clock, and each result appears a fixed number of cycles later, in the same way whether suppression is on or off. The result is four registered slots, strongest first, and each slot has its own valid flag.

Top module: `cand_rank_sorter`

## Requirements
- R1: The block accepts one event per clock. The result for an event presented before rising edge k is on the outputs just after rising edge k+3, so latency is 4 edges, and it is the same with suppression on or off.
- R2: A candidate is 16 bits: quality [15:13], momentum [12:8], wedge tag [7:4], sub-sector [3:0]. Candidate i of wedge w sits at cand_i[(w*12+i)*16 +: 16]. Quality 0 marks an empty input, and an empty input never reaches an output.
- R3: Higher quality ranks first. At equal quality, the higher momentum code ranks first.
- R4: Equal ranks are resolved by position. The lower wedge position wins, and within a wedge the lower input index wins.
- R5: With dup_en_i high, candidate j of a wedge is cleared if some lower-index candidate i of the same wedge meets all of these: both are non-empty, the quality codes are equal, the momentum codes are equal, and the sub-sector indices differ by exactly one with no wraparound (15 and 0 are not neighbours). Candidate i does this even if i is itself cleared.
- R6: With dup_en_i low, no candidate is cleared.
- R7: At most two candidates from any one wedge appear among the four outputs.
- R8: Slot 0 holds the strongest result and slot 3 the weakest. The valid slots form a contiguous run starting at slot 0.
- R9: A slot with no surviving candidate has its valid flag low and all 16 bits zero.
- R10: While rst_ni is low, all outputs are zero.
- R11: dup_en_i is sampled together with its own event, so consecutive events may use different settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Event clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dup_en_i | input | 1 | Enables duplicate suppression for the event presented this cycle |
| cand_i | input | 2304 | 144 candidates, 16 bits each, wedge-major order |
| best_o | output | 64 | Four result slots, slot k at bits [k*16 +: 16] |
| best_vld_o | output | 4 | Valid flag per result slot |

## Verification
Every result is due exactly four rising edges after its event is sampled. The bench drives each event on a falling edge and compares the outputs on the falling edge four cycles later. It keeps a short ring of expected results, indexed by event number, so that back-to-back events can be checked while the pipeline stays full. The assertions that tie outputs to past inputs use a cycles-since-reset counter, so they never look back before reset was released.

// File: rtl/cand_sorter_pkg.sv
package cand_sorter_pkg;
  localparam int QUAL_W = 3;
  localparam int PT_W   = 5;
  localparam int TAG_W  = 4;
  localparam int SUB_W  = 4;
  localparam int KEY_W  = QUAL_W + PT_W;

  typedef struct packed {
    logic [QUAL_W-1:0] qual;
    logic [PT_W-1:0]   pt;
    logic [TAG_W-1:0]  wedge;
    logic [SUB_W-1:0]  sub;
  } cand_t;

  localparam int CAND_W = $bits(cand_t);

  function automatic logic [KEY_W-1:0] rank_key(cand_t c);
    return {c.qual, c.pt};
  endfunction

  // no wraparound: widen before adding
  function automatic logic is_adjacent(logic [SUB_W-1:0] a, logic [SUB_W-1:0] b);
    logic [SUB_W:0] ea, eb;
    ea = {1'b0, a};
    eb = {1'b0, b};
    return (ea == eb + (SUB_W+1)'(1)) || (eb == ea + (SUB_W+1)'(1));
  endfunction
endpackage

// File: rtl/cand_dup_filter.sv
module cand_dup_filter
  import cand_sorter_pkg::*;
#(
  parameter int N = 12
) (
  input  logic  en_i,
  input  cand_t cand_i [N],
  output cand_t cand_o [N]
);
  always_comb begin
    logic kill;
    for (int j = 0; j < N; j++) begin
      kill = 1'b0;
      for (int i = 0; i < j; i++) begin
        if (en_i && cand_i[i].qual != '0 && cand_i[j].qual != '0 &&
            rank_key(cand_i[i]) == rank_key(cand_i[j]) &&
            is_adjacent(cand_i[i].sub, cand_i[j].sub))
          kill = 1'b1;
      end
      cand_o[j] = kill ? '0 : cand_i[j];
    end
  end
endmodule

// File: rtl/cand_rank_select.sv
module cand_rank_select
  import cand_sorter_pkg::*;
#(
  parameter int N = 12,
  parameter int K = 2
) (
  input  cand_t          cand_i [N],
  output cand_t          sel_o  [K],
  output logic [K-1:0]   vld_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  // repeated max-pick; strict '>' keeps the lowest index on ties
  always_comb begin
    logic [N-1:0]  taken;
    logic          found;
    logic [IW-1:0] bi;
    taken = '0;
    for (int k = 0; k < K; k++) begin
      found = 1'b0;
      bi    = '0;
      for (int i = 0; i < N; i++) begin
        if (!taken[i] && cand_i[i].qual != '0 &&
            (!found || rank_key(cand_i[i]) > rank_key(cand_i[bi]))) begin
          found = 1'b1;
          bi    = i[IW-1:0];
        end
      end
      vld_o[k] = found;
      if (found) begin
        taken[bi] = 1'b1;
        sel_o[k]  = cand_i[bi];
      end else begin
        sel_o[k]  = '0;
      end
    end
  end
endmodule

// File: rtl/cand_rank_sorter.sv
module cand_rank_sorter
  import cand_sorter_pkg::*;
#(
  parameter int NUM_WEDGES   = 12,
  parameter int WEDGE_INPUTS = 12,
  parameter int WEDGE_KEEP   = 2,
  parameter int NUM_OUT      = 4
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      dup_en_i,
  input  logic [NUM_WEDGES*WEDGE_INPUTS*CAND_W-1:0] cand_i,
  output logic [NUM_OUT*CAND_W-1:0]                 best_o,
  output logic [NUM_OUT-1:0]                        best_vld_o
);
  localparam int NUM_MID = NUM_WEDGES * WEDGE_KEEP;

  cand_t in_arr  [NUM_WEDGES][WEDGE_INPUTS];
  cand_t s0_cand [NUM_WEDGES][WEDGE_INPUTS];
  logic  s0_en;
  cand_t flt     [NUM_WEDGES][WEDGE_INPUTS];
  cand_t s1_cand [NUM_WEDGES][WEDGE_INPUTS];
  cand_t wsel    [NUM_WEDGES][WEDGE_KEEP];
  cand_t s2_cand [NUM_MID];
  cand_t gsel    [NUM_OUT];
  logic  [NUM_OUT-1:0] gvld;
  cand_t out_q   [NUM_OUT];
  logic  [NUM_OUT-1:0] out_vld_q;

  always_comb begin
    for (int w = 0; w < NUM_WEDGES; w++)
      for (int i = 0; i < WEDGE_INPUTS; i++)
        in_arr[w][i] = cand_i[(w*WEDGE_INPUTS+i)*CAND_W +: CAND_W];
  end

  // stage 0: capture event and its suppression setting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_en <= 1'b0;
      for (int w = 0; w < NUM_WEDGES; w++)
        for (int i = 0; i < WEDGE_INPUTS; i++)
          s0_cand[w][i] <= '0;
    end else begin
      s0_en   <= dup_en_i;
      s0_cand <= in_arr;
    end
  end

  // stage 1: duplicate suppression, stage 2: per-wedge top-K
  for (genvar w = 0; w < NUM_WEDGES; w++) begin : g_wedge
    logic [WEDGE_KEEP-1:0] wvld_unused;

    cand_dup_filter #(.N(WEDGE_INPUTS)) u_flt (
      .en_i  (s0_en),
      .cand_i(s0_cand[w]),
      .cand_o(flt[w])
    );

    cand_rank_select #(.N(WEDGE_INPUTS), .K(WEDGE_KEEP)) u_wsel (
      .cand_i(s1_cand[w]),
      .sel_o (wsel[w]),
      .vld_o (wvld_unused)
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NUM_WEDGES; w++)
        for (int i = 0; i < WEDGE_INPUTS; i++)
          s1_cand[w][i] <= '0;
    end else begin
      s1_cand <= flt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int m = 0; m < NUM_MID; m++) s2_cand[m] <= '0;
    end else begin
      for (int w = 0; w < NUM_WEDGES; w++)
        for (int s = 0; s < WEDGE_KEEP; s++)
          s2_cand[w*WEDGE_KEEP+s] <= wsel[w][s];
    end
  end

  // stage 3: global top-N over wedge winners, wedge-major order
  cand_rank_select #(.N(NUM_MID), .K(NUM_OUT)) u_gsel (
    .cand_i(s2_cand),
    .sel_o (gsel),
    .vld_o (gvld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q <= '0;
      for (int k = 0; k < NUM_OUT; k++) out_q[k] <= '0;
    end else begin
      out_vld_q <= gvld;
      out_q     <= gsel;
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_OUT; k++)
      best_o[k*CAND_W +: CAND_W] = out_q[k];
  end
  assign best_vld_o = out_vld_q;
endmodule

// File: rtl/cand_rank_sorter_chk.sv
module cand_rank_sorter_chk
  import cand_sorter_pkg::*;
#(
  parameter int NUM_WEDGES   = 12,
  parameter int WEDGE_INPUTS = 12,
  parameter int NUM_OUT      = 4
) (
  input logic                                      clk_i,
  input logic                                      rst_ni,
  input logic [NUM_WEDGES*WEDGE_INPUTS*CAND_W-1:0] cand_i,
  input logic [NUM_OUT*CAND_W-1:0]                 best_o,
  input logic [NUM_OUT-1:0]                        best_vld_o
);
  localparam int NUM_CAND = NUM_WEDGES * WEDGE_INPUTS;

  logic       any_in;
  logic [2:0] live_cnt;

  always_comb begin
    any_in = 1'b0;
    for (int f = 0; f < NUM_CAND; f++)
      if (cand_i[f*CAND_W+CAND_W-1 -: QUAL_W] != '0) any_in = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                live_cnt <= '0;
    else if (live_cnt != 3'd5)  live_cnt <= live_cnt + 3'd1;
  end

  // the first non-empty input of a wedge is never suppressed
  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_cnt == 3'd5) |-> (best_vld_o[0] == $past(any_in, 4))); // R1

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_slot
    AST_VALID_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      best_vld_o[k] |-> (best_o[k*CAND_W+CAND_W-1 -: QUAL_W] != '0)); // R2
    AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !best_vld_o[k] |-> (best_o[k*CAND_W +: CAND_W] == '0)); // R9
    if (k + 1 < NUM_OUT) begin : g_pair
      AST_SORTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        best_vld_o[k+1] |-> (best_vld_o[k] &&
          best_o[k*CAND_W+CAND_W-1 -: KEY_W] >= best_o[(k+1)*CAND_W+CAND_W-1 -: KEY_W])); // R8
    end
  end
endmodule

bind cand_rank_sorter cand_rank_sorter_chk #(
  .NUM_WEDGES  (NUM_WEDGES),
  .WEDGE_INPUTS(WEDGE_INPUTS),
  .NUM_OUT     (NUM_OUT)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cand_i    (cand_i),
  .best_o    (best_o),
  .best_vld_o(best_vld_o)
);

// File: tb/cand_rank_sorter_tb.sv
`timescale 1ns/1ps
module cand_rank_sorter_tb;
  localparam int NW = 12, NC = 12, NT = NW*NC, NO = 4, CW = 16;
  localparam int NDIR = 9, NRAND = 400, NTOT = NDIR + NRAND + 4;

  logic clk_i = 1'b0, rst_ni = 1'b0, dup_en_i = 1'b0;
  logic [NT*CW-1:0] cand_i = '0;
  logic [NO*CW-1:0] best_o;
  logic [NO-1:0]    best_vld_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] ev [NT];
  bit          ev_en;
  logic [NO*CW-1:0] exp_c [8];
  logic [NO-1:0]    exp_v [8];
  string            exp_t [8];

  always #2.5 clk_i = ~clk_i;

  cand_rank_sorter u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .dup_en_i(dup_en_i),
    .cand_i(cand_i), .best_o(best_o), .best_vld_o(best_vld_o)
  );

  function automatic bit beats(logic [15:0] x, int ix, logic [15:0] y, int iy);
    return (x[15:8] > y[15:8]) || (x[15:8] == y[15:8] && ix < iy);
  endfunction

  task automatic clear_ev();
    for (int f = 0; f < NT; f++) ev[f] = '0;
  endtask

  task automatic put(int w, int i, int q, int pt, int sub);
    ev[w*NC+i] = {q[2:0], pt[4:0], w[3:0], sub[3:0]};
  endtask

  // reference: rank-count method on survivors
  task automatic calc_expected(int slot);
    logic [15:0] surv [NT];
    bit kept [NT];
    int rank, d;
    for (int f = 0; f < NT; f++) surv[f] = ev[f];
    if (ev_en)
      for (int w = 0; w < NW; w++)
        for (int j = 0; j < NC; j++)
          for (int i = 0; i < j; i++) begin
            d = int'(ev[w*NC+i][3:0]) - int'(ev[w*NC+j][3:0]);
            if (ev[w*NC+i][15:13] != 0 && ev[w*NC+j][15:13] != 0 &&
                ev[w*NC+i][15:8] == ev[w*NC+j][15:8] && (d == 1 || d == -1))
              surv[w*NC+j] = '0;
          end
    for (int f = 0; f < NT; f++) begin
      kept[f] = 0;
      if (surv[f][15:13] != 0) begin
        rank = 0;
        for (int g = (f/NC)*NC; g < (f/NC)*NC + NC; g++)
          if (g != f && surv[g][15:13] != 0 && beats(surv[g], g, surv[f], f)) rank++;
        kept[f] = (rank < 2);
      end
    end
    exp_c[slot] = '0;
    exp_v[slot] = '0;
    for (int f = 0; f < NT; f++)
      if (kept[f]) begin
        rank = 0;
        for (int g = 0; g < NT; g++)
          if (kept[g] && g != f && beats(surv[g], g, surv[f], f)) rank++;
        if (rank < NO) begin
          exp_c[slot][rank*CW +: CW] = surv[f];
          exp_v[slot][rank] = 1'b1;
        end
      end
  endtask

  task automatic build_event(int n, output string tag);
    clear_ev();
    ev_en = 1;
    tag = "R1 R3 R4 R5 R6 R8 R11 random";
    case (n)
      0: tag = "R9 empty event";
      1: begin put(6, 4, 2, 7, 3); tag = "R9 single candidate"; end
      2: begin put(3, 0, 3, 31, 0); put(5, 2, 4, 1, 0); put(1, 1, 3, 30, 0);
               tag = "R3 quality over momentum"; end
      3: begin put(0, 0, 5, 3, 0); put(2, 0, 5, 20, 0); put(9, 5, 5, 9, 0); put(11, 11, 5, 4, 0);
               tag = "R3 momentum order"; end
      4: begin put(7, 0, 6, 12, 1); put(2, 5, 6, 12, 9); put(2, 1, 6, 12, 12);
               put(10, 3, 6, 12, 2); put(0, 0, 6, 11, 4); tag = "R4 equal-rank order"; end
      5: begin put(0, 0, 5, 10, 5); put(0, 3, 5, 10, 6); put(0, 4, 5, 10, 7); put(0, 6, 5, 11, 6);
               tag = "R5 chained duplicate"; end
      6: begin put(0, 0, 5, 10, 5); put(0, 3, 5, 10, 6); put(0, 4, 5, 10, 7); put(0, 6, 5, 11, 6);
               ev_en = 0; tag = "R6 R11 suppression off"; end
      7: begin put(8, 0, 4, 8, 15); put(8, 1, 4, 8, 0); put(8, 2, 4, 8, 14);
               tag = "R5 no wraparound"; end
      8: begin for (int i = 0; i < 5; i++) put(4, i, 7, 10 + i, 2*i);
               put(9, 0, 1, 0, 0); tag = "R7 two per wedge"; end
      default: begin
        if (n >= NDIR + NRAND) tag = "R9 drain";
        else begin
          bit narrow;
          narrow = ($urandom % 2) == 0;
          ev_en = ($urandom % 2) == 1;
          for (int f = 0; f < NT; f++)
            if ($urandom % 3 != 0) begin
              if (narrow) put(f/NC, f%NC, 1 + $urandom % 2, $urandom % 4, $urandom % 16);
              else        put(f/NC, f%NC, $urandom % 8, $urandom % 32, $urandom % 16);
            end
        end
      end
    endcase
  endtask

  task automatic check_out(int slot);
    checks++;
    if (best_o !== exp_c[slot] || best_vld_o !== exp_v[slot]) begin
      errors++;
      $display("FAIL %s: got vld=%b data=%h, expected vld=%b data=%h",
               exp_t[slot], best_vld_o, best_o, exp_v[slot], exp_c[slot]);
    end
  endtask

  initial begin
    string tag;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    checks++;
    if (best_o !== '0 || best_vld_o !== '0) begin
      errors++;
      $display("FAIL R10: got vld=%b data=%h, expected all zero", best_vld_o, best_o);
    end
    rst_ni = 1'b1;
    for (int n = 0; n < NTOT; n++) begin
      @(negedge clk_i);
      if (n >= 4) check_out((n - 4) % 8);
      build_event(n, tag);
      calc_expected(n % 8);
      exp_t[n % 8] = tag;
      dup_en_i = ev_en;
      for (int f = 0; f < NT; f++) cand_i[f*CW +: CW] = ev[f];
    end
    for (int n = NTOT; n < NTOT + 4; n++) begin
      @(negedge clk_i);
      check_out((n - 4) % 8);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1: watchdog expired, got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule